// File: doc/BRIEF.md
# Dual-Mode Transfer Count Unit

This block holds the working state of one data-transfer channel: a 24-bit source pointer, a 24-bit destination pointer and a 16-bit count word. Software fills these through a small write port. After that, each transfer-complete pulse from the data mover advances the state by one step. Each pointer either moves forward by the transfer width or stays where it is, and the count word is consumed.

A mode input chooses how the count word is used. In linear mode all 16 bits form a single down-counter, and the block raises a one-cycle `end_pulse` when that counter reaches zero. In split mode the low byte counts down and the high byte is a reload value. When the low byte runs out, it is refilled from the high byte, a one-cycle `wrap_pulse` is raised, and the pointer chosen as the repeat side returns to the value software last wrote into it.

A word transfer needs both pointers to be even. A word step requested while either pointer is odd is refused: the block raises `align_fault` for one cycle and leaves all state unchanged.

Top module: `xfer_count_unit`

## Requirements
- R1: After reset both pointers and the count word read zero, and `end_pulse`, `wrap_pulse` and `align_fault` are low.
- R2: A write with `wr_en` high loads `wr_data` on the next clock. `wr_sel` 0 selects the source pointer, 1 selects the destination pointer, and 2 selects the count word (low 16 bits of `wr_data`). `wr_sel` 3 changes nothing.
- R3: On an accepted step, a pointer whose step flag is 1 advances by 1 when `word_mode` is 0 and by 2 when `word_mode` is 1, wrapping modulo 2^24. A pointer whose flag is 0 keeps its value.
- R4: In linear mode (`split_mode` 0) an accepted step lowers the 16-bit count by one. A count of zero steps to 0xFFFF, so a loaded zero stands for 65536 transfers.
- R5: `end_pulse` is high for exactly the one cycle after the step that takes a linear-mode count from 1 to 0. It never rises in split mode.
- R6: In split mode (`split_mode` 1) an accepted step lowers the low byte by one and leaves the high byte as it is. A low byte of zero steps to 0xFF, so zero stands for 256 transfers.
- R7: In split mode, a step that takes the low byte from 1 to 0 instead loads the low byte with the high byte and raises `wrap_pulse` for one cycle.
- R8: On a split-mode reload, the pointer named by `repeat_dst` (1 = destination, 0 = source) returns to the value last written to it through the port, and the other pointer steps as in R3.
- R9: A step with `word_mode` 1 while either pointer has bit 0 set raises `align_fault` for one cycle and leaves pointers, count, `end_pulse` and `wrap_pulse` unchanged.
- R10: When `wr_en` and `xfer_pulse` are high in the same cycle, the write takes effect and the step is dropped without any pulse.
- R11: The three pulse outputs are registered and mutually exclusive. None of them is high unless `xfer_pulse` was high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 source, 1 destination, 2 count |
| wr_data | input | 24 | Write data |
| split_mode | input | 1 | 0 linear 16-bit count, 1 split reload count |
| word_mode | input | 1 | 0 byte steps, 1 word steps |
| src_step | input | 1 | Source pointer advances when 1 |
| dst_step | input | 1 | Destination pointer advances when 1 |
| repeat_dst | input | 1 | Repeat side for reload: 1 destination, 0 source |
| xfer_pulse | input | 1 | One transfer completed |
| src_addr | output | 24 | Current source pointer |
| dst_addr | output | 24 | Current destination pointer |
| count | output | 16 | Current count word |
| end_pulse | output | 1 | Linear count reached zero |
| wrap_pulse | output | 1 | Split low byte was reloaded |
| align_fault | output | 1 | Word step refused on an odd pointer |

## Verification
Two functions can meet in one cycle. The first is a register write arriving together with a transfer pulse. This is provoked on purpose and also happens often in the random phase, and it is judged by checking that the written value appears while no pulse rises and no count is consumed. The second is a split-mode reload, where the repeat-side pointer is restored while the other pointer still advances. This is run with each side chosen as the repeat side and with the 256-transfer case. A behavioural reference model in the bench predicts every output and is compared with the design on each clock.

// File: rtl/xfer_count_unit.sv
module xfer_count_unit #(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          split_mode,
  input  logic          word_mode,
  input  logic          src_step,
  input  logic          dst_step,
  input  logic          repeat_dst,
  input  logic          xfer_pulse,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [CW-1:0] count,
  output logic          end_pulse,
  output logic          wrap_pulse,
  output logic          align_fault
);
  localparam int HW = CW / 2;

  logic [AW-1:0] src_q, dst_q, src_base, dst_base;
  logic [CW-1:0] cnt_q;
  logic          end_q, wrap_q, fault_q;

  // R10: a write in the same cycle wins over a step
  wire go        = xfer_pulse && !wr_en;
  wire odd_ptr   = word_mode && (src_q[0] || dst_q[0]);
  wire take      = go && !odd_ptr;

  // R3: step size from transfer width
  wire [AW-1:0] inc = {{(AW-2){1'b0}}, word_mode, !word_mode};
  wire [AW-1:0] src_adv = src_step ? src_q + inc : src_q;
  wire [AW-1:0] dst_adv = dst_step ? dst_q + inc : dst_q;

  wire [HW-1:0] lo = cnt_q[HW-1:0];
  wire [HW-1:0] hi = cnt_q[CW-1:HW];
  wire [HW-1:0] lo_one = {{(HW-1){1'b0}}, 1'b1};
  wire [CW-1:0] cw_one = {{(CW-1){1'b0}}, 1'b1};

  // R6, R7: split-mode reload when the low byte leaves one
  wire reload  = split_mode && (lo == lo_one);
  // R5: linear count finishing
  wire finish  = !split_mode && (cnt_q == cw_one);

  logic [CW-1:0] cnt_nx;
  always_comb begin
    if (!split_mode)  cnt_nx = cnt_q - cw_one;
    else if (reload)  cnt_nx = {hi, hi};
    else              cnt_nx = {hi, lo - lo_one};
  end

  // R8: repeat side returns to its written value on reload
  wire [AW-1:0] src_nx = (reload && !repeat_dst) ? src_base : src_adv;
  wire [AW-1:0] dst_nx = (reload &&  repeat_dst) ? dst_base : dst_adv;

  // R1, R2: registers and write port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= '0;
      dst_q    <= '0;
      src_base <= '0;
      dst_base <= '0;
      cnt_q    <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: begin src_q <= wr_data; src_base <= wr_data; end
        2'd1: begin dst_q <= wr_data; dst_base <= wr_data; end
        2'd2: cnt_q <= wr_data[CW-1:0];
        default: ;
      endcase
    end else if (take) begin
      src_q <= src_nx;
      dst_q <= dst_nx;
      cnt_q <= cnt_nx;
    end
  end

  // R9, R11: one-cycle status pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q   <= 1'b0;
      wrap_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      end_q   <= take && finish;
      wrap_q  <= take && reload;
      fault_q <= go && odd_ptr;
    end
  end

  assign src_addr    = src_q;
  assign dst_addr    = dst_q;
  assign count       = cnt_q;
  assign end_pulse   = end_q;
  assign wrap_pulse  = wrap_q;
  assign align_fault = fault_q;
endmodule

// File: rtl/xfer_count_unit_chk.sv
module xfer_count_unit_chk #(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [AW-1:0] wr_data,
  input logic          split_mode,
  input logic          xfer_pulse,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] dst_addr,
  input logic [CW-1:0] count,
  input logic          end_pulse,
  input logic          wrap_pulse,
  input logic          align_fault
);
  localparam int HW = CW / 2;

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({end_pulse, wrap_pulse, align_fault})); // R11

  AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_pulse |=> !(end_pulse || wrap_pulse || align_fault)); // R11

  AST_FAULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> ($stable(src_addr) && $stable(dst_addr) && $stable(count))); // R9

  AST_END_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    end_pulse |-> (count == '0 && $past(count) == {{(CW-1){1'b0}}, 1'b1})); // R5

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> (count[HW-1:0] == count[CW-1:HW])); // R7

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2) |=> (count == $past(wr_data[CW-1:0]))); // R10

  AST_WRITE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> (src_addr == $past(wr_data))); // R2

  AST_SPLIT_NO_END: assert property (@(posedge clk) disable iff (!rst_n)
    (split_mode && $stable(split_mode)) |-> !end_pulse); // R5
endmodule

bind xfer_count_unit xfer_count_unit_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .split_mode(split_mode), .xfer_pulse(xfer_pulse), .src_addr(src_addr),
  .dst_addr(dst_addr), .count(count), .end_pulse(end_pulse),
  .wrap_pulse(wrap_pulse), .align_fault(align_fault)
);

// File: tb/xfer_count_unit_bench.sv
module xfer_count_unit_bench;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, split_mode = 0, word_mode = 0, src_step = 1, dst_step = 1;
  logic repeat_dst = 0, xfer_pulse = 0;
  logic [1:0] wr_sel = 0;
  logic [23:0] wr_data = 0;
  logic [23:0] src_addr, dst_addr;
  logic [15:0] count;
  logic end_pulse, wrap_pulse, align_fault;

  always #10 clk = ~clk;

  xfer_count_unit u_xfer_count_unit (.*);

  int checks = 0, failures = 0, cycles = 0;
  string cur_req = "R1";
  bit finished = 0;

  // behavioural reference model
  int m_src, m_dst, m_src0, m_dst0, m_cnt;
  bit m_end, m_wrap, m_fault;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_src = 0; m_dst = 0; m_src0 = 0; m_dst0 = 0; m_cnt = 0;
      m_end = 0; m_wrap = 0; m_fault = 0;
    end else begin
      int stp, ns, nd, c, lo, hi;
      m_end = 0; m_wrap = 0; m_fault = 0;
      if (wr_en) begin
        if (wr_sel == 0) begin m_src = wr_data; m_src0 = wr_data; end
        else if (wr_sel == 1) begin m_dst = wr_data; m_dst0 = wr_data; end
        else if (wr_sel == 2) m_cnt = wr_data[15:0];
      end else if (xfer_pulse) begin
        if (word_mode && ((m_src % 2) == 1 || (m_dst % 2) == 1)) m_fault = 1;
        else begin
          stp = word_mode ? 2 : 1;
          ns = src_step ? (m_src + stp) % (1 << 24) : m_src;
          nd = dst_step ? (m_dst + stp) % (1 << 24) : m_dst;
          if (!split_mode) begin
            c = (m_cnt == 0) ? 65536 : m_cnt;
            c = c - 1;
            if (c == 0) m_end = 1;
            m_cnt = c;
          end else begin
            hi = m_cnt / 256;
            lo = m_cnt % 256;
            if (lo == 0) lo = 256;
            lo = lo - 1;
            if (lo == 0) begin
              lo = hi; m_wrap = 1;
              if (repeat_dst) nd = m_dst0; else ns = m_src0;
            end
            m_cnt = hi * 256 + lo;
          end
          m_src = ns; m_dst = nd;
        end
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk("src_addr", src_addr, m_src);
    chk("dst_addr", dst_addr, m_dst);
    chk("count", count, m_cnt);
    chk("end_pulse", end_pulse, m_end);
    chk("wrap_pulse", wrap_pulse, m_wrap);
    chk("align_fault", align_fault, m_fault);
  end

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      summary();
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wr_en = 0; xfer_pulse = 0;
    end
  endtask

  task automatic wr(int sel, int data);
    @(negedge clk); xfer_pulse = 0; wr_en = 1; wr_sel = sel[1:0]; wr_data = data[23:0];
    @(negedge clk); wr_en = 0;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wr_en = 0; xfer_pulse = 1;
    end
    @(negedge clk); xfer_pulse = 0;
  endtask

  initial begin
    // R1: reset state
    #35 rst_n = 1;
    @(negedge clk);
    chk("reset count", count, 0);
    chk("reset end", end_pulse, 0);

    // R2, R4, R5, R3 byte steps, linear countdown to zero then 0xFFFF
    cur_req = "R2";
    wr(0, 24'h000100); wr(1, 24'h000200); wr(2, 3);
    chk("R2 src written", src_addr, 24'h100);
    cur_req = "R4";
    split_mode = 0; word_mode = 0; src_step = 1; dst_step = 1;
    steps(2);
    cur_req = "R5";
    @(negedge clk); xfer_pulse = 1;
    @(negedge clk); xfer_pulse = 0;
    chk("R5 end_pulse after last step", end_pulse, 1);
    chk("R5 count zero", count, 0);
    cur_req = "R4";
    steps(1);
    chk("R4 zero wraps to FFFF", count, 16'hFFFF);

    // R3 word steps, source fixed
    cur_req = "R3";
    word_mode = 1; src_step = 0; dst_step = 1;
    wr(0, 24'h000400); wr(1, 24'h000800); wr(2, 2);
    steps(2);
    chk("R3 dst +2 per word", dst_addr, 24'h000804);
    chk("R3 src fixed", src_addr, 24'h000400);
    // R3 address wraps at 24 bits
    word_mode = 0; src_step = 1;
    wr(0, 24'hFFFFFF); steps(1);
    chk("R3 src wraps", src_addr, 0);

    // R9 misaligned word step
    cur_req = "R9";
    wr(0, 24'h000401); word_mode = 1; wr(2, 1);
    @(negedge clk); xfer_pulse = 1;
    @(negedge clk); xfer_pulse = 0;
    chk("R9 fault raised", align_fault, 1);
    chk("R9 count kept", count, 1);
    chk("R9 no end pulse", end_pulse, 0);
    wr(0, 24'h000402); wr(1, 24'h000803); steps(2);
    word_mode = 0;

    // R6, R7, R8 split mode, source repeat side
    cur_req = "R7";
    split_mode = 1; repeat_dst = 0; src_step = 1; dst_step = 1;
    wr(0, 24'h001000); wr(1, 24'h002000); wr(2, 16'h0302);
    cur_req = "R6";
    steps(1);
    chk("R6 low byte dec", count, 16'h0301);
    cur_req = "R8";
    @(negedge clk); xfer_pulse = 1;
    @(negedge clk); xfer_pulse = 0;
    chk("R7 wrap pulse", wrap_pulse, 1);
    chk("R7 reloaded", count, 16'h0303);
    chk("R8 src restored", src_addr, 24'h001000);
    chk("R8 dst stepped", dst_addr, 24'h002002);
    steps(7);

    // R6 zero low byte means 256, destination repeat side
    cur_req = "R6";
    repeat_dst = 1;
    wr(1, 24'h003000); wr(2, 16'h0100);
    steps(255);
    chk("R6 256 count near end", count, 16'h0101);
    cur_req = "R8";
    steps(1);
    chk("R8 dst restored", dst_addr, 24'h003000);
    steps(3);

    // R10 write and step together
    cur_req = "R10";
    split_mode = 0;
    wr(2, 5);
    @(negedge clk); wr_en = 1; wr_sel = 2; wr_data = 24'h000009; xfer_pulse = 1;
    @(negedge clk); wr_en = 0; xfer_pulse = 0;
    chk("R10 write won", count, 9);
    chk("R10 no pulse", end_pulse | wrap_pulse | align_fault, 0);

    // R2 select 3 has no effect
    cur_req = "R2";
    wr(3, 24'hABCDEF);
    chk("R2 sel3 count kept", count, 9);
    chk("R2 sel3 src kept", src_addr, m_src);

    // R11 mixed random traffic
    cur_req = "R11";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      wr_en = ($urandom % 8) == 0;
      wr_sel = 2'($urandom % 4);
      wr_data = 24'($urandom);
      if (($urandom % 4) != 0) wr_data[0] = 0;
      if (wr_sel == 2 && ($urandom % 2) == 1) wr_data[15:0] = 16'($urandom % 6);
      xfer_pulse = ($urandom % 3) != 0;
      if (($urandom % 64) == 0) split_mode = ~split_mode;
      if (($urandom % 32) == 0) word_mode = ~word_mode;
      src_step = ($urandom % 4) != 0;
      dst_step = ($urandom % 4) != 0;
      repeat_dst = 1'($urandom % 2);
    end
    idle(3);
    summary();
  end
endmodule